// File: doc/BRIEF.md
# Cache maintenance operation controller

This controller runs beside a data cache pipeline and carries out maintenance requests from any of several requesters. A request is taken with a valid/ready handshake. It is recognised by a dedicated maintenance opcode, and a three-bit subtype field selects the operation. The controller then steps one operation at a time through its own precondition and action, using four neighbours. The write buffer is told to close its open entries and reports how many writes are still pending. The miss tracker reports whether a read miss is outstanding to the looked-up line and how many misses are outstanding in total. The tag/valid array answers hit lookups and takes invalidate strobes for one line or for every way of a set. The refill port fetches a line from memory and reports when that line is installed.

The four operations each have their own precondition. A write fence drains the pending writes. A line invalidate waits until any read miss to the same line has cleared. A whole-cache invalidate waits until no read miss is outstanding, then clears one set per cycle. A prefetch fetches the line only when the lookup misses. Ready stays low from acceptance until completion, so only one operation is in flight. On completion, a one-cycle response carrying the source and transaction IDs is produced if the request asked for one.

The state machine has these states:

- `S_IDLE`: ready is high.
- `S_FCLOSE`: one cycle that closes the write buffer.
- `S_FDRAIN`: waits until pending writes reach zero.
- `S_TAGCAP`: captures the tag that arrives one cycle late.
- `S_LOOKUP`: waits out a same-line miss, then either invalidates, finishes, or moves to a refill.
- `S_RDRAIN`: waits until all misses are gone.
- `S_SWEEP`: invalidates one set per cycle.
- `S_REFREQ`: requests the refill.
- `S_REFWAIT`: waits for the refill to finish.
- `S_DONE`: one completion cycle.

The transitions are:

- `S_IDLE` leaves on acceptance:
  - fence goes to `S_FCLOSE`;
  - line invalidate or prefetch goes to `S_LOOKUP` if physical, or `S_TAGCAP` if virtual;
  - invalidate-all goes to `S_RDRAIN`;
  - any other subtype goes to `S_DONE`.
- `S_FCLOSE` goes to `S_FDRAIN`.
- `S_FDRAIN` goes to `S_DONE` when pending writes are zero.
- `S_TAGCAP` goes to `S_LOOKUP`.
- `S_LOOKUP`, once no miss is pending to the line, goes to `S_REFREQ` for a prefetch that misses, and to `S_DONE` otherwise.
- `S_RDRAIN` goes to `S_SWEEP` when the miss count is zero.
- `S_SWEEP` goes to `S_DONE` after the last set.
- `S_REFREQ` goes to `S_REFWAIT` when the refill is accepted.
- `S_REFWAIT` goes to `S_DONE` when the refill is done.
- `S_DONE` goes to `S_IDLE`.

Top module: `cmo_ctrl`

## Requirements
- R1: The subtype in `req_size` is decoded as 3'b000 write fence, 3'b010 line invalidate, 3'b100 invalidate all and 3'b101 prefetch. Any other value performs no action and completes with `S_DONE` in the cycle right after acceptance.
- R2: With `CMO_EN` = 0, `req_ready` is always 0, and no close, invalidate, refill or response strobe is ever produced.
- R3: A request is taken only on a cycle where `req_valid` and `req_ready` are both 1 and `req_op` equals `OP_CMO`. A valid request with another opcode has no effect, and `req_ready` stays 1.
- R4: A fence asserts `wbuf_close` for exactly the first cycle after acceptance. Ready stays low while `wbuf_pending` is nonzero. The operation completes the cycle after `S_FDRAIN` sees zero pending writes, at the earliest in the third cycle after acceptance.
- R5: A line invalidate that hits with no miss pending gives one `inval_valid` strobe, with `inval_all_ways` = 0 and the request's set and tag. The strobe comes in the first lookup cycle, and completion follows one cycle later.
- R6: While `look_miss_pend` is 1 for the target line, a line invalidate or prefetch waits in `S_LOOKUP`. It acts on the line only after the miss clears.
- R7: A line invalidate whose lookup misses produces no invalidate strobe, and the array is left unchanged.
- R8: Invalidate-all waits until `miss_count` is zero. It then strobes `inval_valid` with `inval_all_ways` = 1 for NUM_SETS consecutive cycles, with sets 0 up to NUM_SETS-1 in ascending order, and completes the next cycle.
- R9: A prefetch that hits issues no refill. A prefetch that misses raises `refill_valid` once with the line's set and tag, and completes in the cycle after `refill_done`.
- R10: For line operations, the tag is `req_tag` when `req_phys` = 1. When `req_phys` = 0, the tag is `late_tag` as sampled in the cycle after acceptance, and the lookup starts one cycle later.
- R11: In the completion cycle, `rsp_valid` pulses for one cycle with the request's `req_sid` and `req_tid`, but only when `req_need_rsp` was 1.
- R12: `req_ready` is 0 from the cycle after acceptance through the completion cycle, and 1 again in the cycle that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_op | input | OP_W | Request opcode |
| req_size | input | 3 | Maintenance subtype |
| req_sid | input | SID_W | Source ID |
| req_tid | input | TID_W | Transaction ID |
| req_need_rsp | input | 1 | Completion response wanted |
| req_phys | input | 1 | Tag carried in the request (1) or on late_tag (0) |
| req_set | input | SET_W | Set index of the target line |
| req_tag | input | TAG_W | Upper address bits for physical indexing |
| late_tag | input | TAG_W | Upper address bits one cycle after acceptance |
| wbuf_close | output | 1 | Close all open write-buffer entries |
| wbuf_pending | input | WCNT_W | Writes awaiting memory acknowledge |
| look_set | output | SET_W | Lookup set |
| look_tag | output | TAG_W | Lookup tag |
| look_miss_pend | input | 1 | Read miss pending to the looked-up line |
| miss_count | input | MCNT_W | Outstanding read misses |
| look_hit | input | 1 | Looked-up line present |
| inval_valid | output | 1 | Invalidate strobe |
| inval_all_ways | output | 1 | Strobe clears every way of the set |
| inval_set | output | SET_W | Set to invalidate |
| inval_tag | output | TAG_W | Tag to invalidate (single line) |
| refill_valid | output | 1 | Refill request |
| refill_ready | input | 1 | Refill request taken |
| refill_set | output | SET_W | Refill set |
| refill_tag | output | TAG_W | Refill tag |
| refill_done | input | 1 | Refilled line installed |
| rsp_valid | output | 1 | Completion response |
| rsp_sid | output | SID_W | Response source ID |
| rsp_tid | output | TID_W | Response transaction ID |

## Verification
Line invalidates are tried against three array states: a matching line, an empty set, and a set holding another tag. Together these separate a real invalidate from a stray strobe, and the exact cycle counts show whether the lookup takes one or two cycles depending on the tag source. Pending-miss lengths shorter and longer than the lookup delay show whether a line operation truly waits, and whether invalidate-all holds off its sweep. Fence drain depths of zero and several writes show the minimum latency and the ready hold. Prefetch is tried on a hit, a miss and a pending miss, which separates a refill from no refill, and random mixes vary the source and transaction IDs and the response flag.

// File: rtl/cmo_pkg.sv
`timescale 1ns/1ps
package cmo_pkg;
    localparam logic [2:0] SUB_FENCE    = 3'b000;
    localparam logic [2:0] SUB_INV_LINE = 3'b010;
    localparam logic [2:0] SUB_INV_ALL  = 3'b100;
    localparam logic [2:0] SUB_PREFETCH = 3'b101;

    typedef enum logic [2:0] {
        K_FENCE, K_INVL, K_INVA, K_PREF, K_NOP
    } cmo_kind_e;

    typedef enum logic [3:0] {
        S_IDLE, S_FCLOSE, S_FDRAIN, S_TAGCAP, S_LOOKUP,
        S_RDRAIN, S_SWEEP, S_REFREQ, S_REFWAIT, S_DONE
    } cmo_state_e;
endpackage

// File: rtl/cmo_decode.sv
`timescale 1ns/1ps
module cmo_decode
    import cmo_pkg::*;
(
    input  logic [2:0] size,
    output cmo_kind_e  kind
);
    always_comb begin
        unique case (size)
            SUB_FENCE:    kind = K_FENCE;
            SUB_INV_LINE: kind = K_INVL;
            SUB_INV_ALL:  kind = K_INVA;
            SUB_PREFETCH: kind = K_PREF;
            default:      kind = K_NOP;
        endcase
    end
endmodule

// File: rtl/cmo_sweep.sv
`timescale 1ns/1ps
module cmo_sweep #(
    parameter int NUM_SETS = 64,
    parameter int SET_W    = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    output logic [SET_W-1:0] idx,
    output logic             last
);
    localparam logic [SET_W-1:0] LAST_IDX = SET_W'(NUM_SETS - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            idx <= '0;
        else if (clear)
            idx <= '0;
        else if (step && !last)
            idx <= idx + 1'b1;
    end

    assign last = (idx == LAST_IDX);
endmodule

// File: rtl/cmo_ctrl.sv
`timescale 1ns/1ps
module cmo_ctrl
    import cmo_pkg::*;
#(
    parameter int NUM_SETS = 64,
    parameter int TAG_W    = 20,
    parameter int SID_W    = 3,
    parameter int TID_W    = 6,
    parameter int OP_W     = 4,
    parameter int WCNT_W   = 4,
    parameter int MCNT_W   = 4,
    parameter logic [OP_W-1:0] OP_CMO = OP_W'(9),
    parameter bit  CMO_EN  = 1'b1,
    localparam int SET_W   = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [OP_W-1:0]   req_op,
    input  logic [2:0]        req_size,
    input  logic [SID_W-1:0]  req_sid,
    input  logic [TID_W-1:0]  req_tid,
    input  logic              req_need_rsp,
    input  logic              req_phys,
    input  logic [SET_W-1:0]  req_set,
    input  logic [TAG_W-1:0]  req_tag,
    input  logic [TAG_W-1:0]  late_tag,
    output logic              wbuf_close,
    input  logic [WCNT_W-1:0] wbuf_pending,
    output logic [SET_W-1:0]  look_set,
    output logic [TAG_W-1:0]  look_tag,
    input  logic              look_miss_pend,
    input  logic [MCNT_W-1:0] miss_count,
    input  logic              look_hit,
    output logic              inval_valid,
    output logic              inval_all_ways,
    output logic [SET_W-1:0]  inval_set,
    output logic [TAG_W-1:0]  inval_tag,
    output logic              refill_valid,
    input  logic              refill_ready,
    output logic [SET_W-1:0]  refill_set,
    output logic [TAG_W-1:0]  refill_tag,
    input  logic              refill_done,
    output logic              rsp_valid,
    output logic [SID_W-1:0]  rsp_sid,
    output logic [TID_W-1:0]  rsp_tid
);
    cmo_state_e st, st_nx;
    cmo_kind_e  kind_in, kind_q;
    logic [SID_W-1:0] sid_q;
    logic [TID_W-1:0] tid_q;
    logic             rsp_q;
    logic [SET_W-1:0] set_q;
    logic [TAG_W-1:0] tag_q;
    logic [SET_W-1:0] sw_idx;
    logic             sw_last;
    logic             idle_rdy;
    logic             acc;

    generate
        if (CMO_EN) begin : g_en
            assign idle_rdy = (st == S_IDLE);
        end else begin : g_off
            assign idle_rdy = 1'b0;
        end
    endgenerate

    assign acc = req_valid && idle_rdy && (req_op == OP_CMO);

    cmo_decode u_dec (
        .size (req_size),
        .kind (kind_in)
    );

    cmo_sweep #(.NUM_SETS(NUM_SETS), .SET_W(SET_W)) u_sweep (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (acc),
        .step  (st == S_SWEEP),
        .idx   (sw_idx),
        .last  (sw_last)
    );

    // request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q <= K_NOP;
            sid_q  <= '0;
            tid_q  <= '0;
            rsp_q  <= 1'b0;
            set_q  <= '0;
            tag_q  <= '0;
        end else if (acc) begin
            kind_q <= kind_in;
            sid_q  <= req_sid;
            tid_q  <= req_tid;
            rsp_q  <= req_need_rsp;
            set_q  <= req_set;
            tag_q  <= req_tag;
        end else if (st == S_TAGCAP) begin
            tag_q  <= late_tag;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_nx;
    end

    // next state
    always_comb begin
        st_nx = st;
        unique case (st)
            S_IDLE: begin
                if (acc) begin
                    case (kind_in)
                        K_FENCE:       st_nx = S_FCLOSE;
                        K_INVL, K_PREF: st_nx = req_phys ? S_LOOKUP : S_TAGCAP;
                        K_INVA:        st_nx = S_RDRAIN;
                        default:       st_nx = S_DONE;
                    endcase
                end
            end
            S_FCLOSE:  st_nx = S_FDRAIN;
            S_FDRAIN:  if (wbuf_pending == '0) st_nx = S_DONE;
            S_TAGCAP:  st_nx = S_LOOKUP;
            S_LOOKUP: begin
                if (!look_miss_pend)
                    st_nx = (kind_q == K_PREF && !look_hit) ? S_REFREQ : S_DONE;
            end
            S_RDRAIN:  if (miss_count == '0) st_nx = S_SWEEP;
            S_SWEEP:   if (sw_last) st_nx = S_DONE;
            S_REFREQ:  if (refill_ready) st_nx = S_REFWAIT;
            S_REFWAIT: if (refill_done) st_nx = S_DONE;
            S_DONE:    st_nx = S_IDLE;
            default:   st_nx = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready      = idle_rdy;
        wbuf_close     = (st == S_FCLOSE);
        look_set       = set_q;
        look_tag       = tag_q;
        inval_all_ways = (st == S_SWEEP);
        inval_valid    = (st == S_SWEEP) ||
                         (st == S_LOOKUP && kind_q == K_INVL && !look_miss_pend && look_hit);
        inval_set      = (st == S_SWEEP) ? sw_idx : set_q;
        inval_tag      = tag_q;
        refill_valid   = (st == S_REFREQ);
        refill_set     = set_q;
        refill_tag     = tag_q;
        rsp_valid      = (st == S_DONE) && rsp_q;
        rsp_sid        = sid_q;
        rsp_tid        = tid_q;
    end
endmodule

// File: rtl/cmo_ctrl_chk.sv
`timescale 1ns/1ps
module cmo_ctrl_chk
    import cmo_pkg::*;
#(
    parameter int NUM_SETS = 64,
    parameter int OP_W     = 4,
    parameter int MCNT_W   = 4,
    parameter logic [OP_W-1:0] OP_CMO = OP_W'(9),
    parameter bit  CMO_EN  = 1'b1,
    localparam int SET_W   = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [OP_W-1:0]   req_op,
    input logic [2:0]        req_size,
    input logic              wbuf_close,
    input logic              look_miss_pend,
    input logic              look_hit,
    input logic [MCNT_W-1:0] miss_count,
    input logic              inval_valid,
    input logic              inval_all_ways,
    input logic [SET_W-1:0]  inval_set,
    input logic              refill_valid,
    input logic              rsp_valid
);
    logic took;
    assign took = req_valid && req_ready && (req_op == OP_CMO);

    // R12
    ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        took |=> !req_ready);

    // R12
    ready_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> req_ready);

    // R4
    fence_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (took && req_size == SUB_FENCE) |=> wbuf_close);

    // R4
    close_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wbuf_close |=> (!req_ready && !wbuf_close));

    // R6
    inval_nomiss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inval_valid && !inval_all_ways) |-> (!look_miss_pend && look_hit));

    // R8
    sweep_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(inval_all_ways) |-> (inval_set == '0 && miss_count == '0));

    // R8
    sweep_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inval_all_ways && $past(inval_all_ways)) |-> (inval_set == $past(inval_set) + 1'b1));

    // R9
    refill_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        refill_valid |-> !look_hit);

    // R2
    always_comb begin
        if (!CMO_EN) begin
            off_ready_chk: assert (!req_ready);
        end
    end
endmodule

bind cmo_ctrl cmo_ctrl_chk #(
    .NUM_SETS (NUM_SETS),
    .OP_W     (OP_W),
    .MCNT_W   (MCNT_W),
    .OP_CMO   (OP_CMO),
    .CMO_EN   (CMO_EN)
) u_chk (.*);

// File: tb/test_cmo_ctrl.sv
`timescale 1ns/1ps
module test_cmo_ctrl;
    localparam int NS = 16, SW = 4, TW = 12, SIDW = 3, TIDW = 6, OPW = 4;
    localparam int WCW = 4, MCW = 4, RLAT = 3;
    localparam logic [OPW-1:0] OPC = 4'd9;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;
    logic rst_n = 1'b0;

    logic req_valid = 0, req_need_rsp = 0, req_phys = 0;
    logic [OPW-1:0] req_op = '0;
    logic [2:0] req_size = '0;
    logic [SIDW-1:0] req_sid = '0;
    logic [TIDW-1:0] req_tid = '0;
    logic [SW-1:0] req_set = '0;
    logic [TW-1:0] req_tag = '0, late_tag = '0;
    logic req_ready, wbuf_close, look_miss_pend, look_hit, inval_valid, inval_all_ways;
    logic refill_valid, refill_ready, refill_done, rsp_valid;
    logic [WCW-1:0] wbuf_pending;
    logic [MCW-1:0] miss_count;
    logic [SW-1:0] look_set, inval_set, refill_set;
    logic [TW-1:0] look_tag, inval_tag, refill_tag;
    logic [SIDW-1:0] rsp_sid;
    logic [TIDW-1:0] rsp_tid;
    logic off_ready, off_close, off_inv, off_inv_all, off_ref, off_rsp;
    logic [SW-1:0] off_lset, off_iset, off_rset;
    logic [TW-1:0] off_ltag, off_itag, off_rtag;
    logic [SIDW-1:0] off_sid;
    logic [TIDW-1:0] off_tid;

    // stubs
    bit st_v [NS];
    logic [TW-1:0] st_t [NS];
    int wb_cnt = 0, miss_left = 0, ref_left = 0;
    logic [SW-1:0] miss_set = '0, ref_set_q = '0;
    logic [TW-1:0] miss_tag = '0, ref_tag_q = '0;
    logic ref_done = 1'b0;

    assign wbuf_pending   = WCW'(wb_cnt);
    assign miss_count     = (miss_left > 0) ? MCW'(1) : '0;
    assign look_miss_pend = (miss_left > 0) && miss_set == look_set && miss_tag == look_tag;
    assign look_hit       = st_v[look_set] && st_t[look_set] == look_tag;
    assign refill_ready   = 1'b1;
    assign refill_done    = ref_done;

    always @(posedge clk) begin
        if (wb_cnt > 0) wb_cnt <= wb_cnt - 1;
        if (miss_left > 0) begin
            miss_left <= miss_left - 1;
            if (miss_left == 1) begin st_v[miss_set] <= 1; st_t[miss_set] <= miss_tag; end
        end
        ref_done <= 1'b0;
        if (refill_valid && refill_ready) begin
            ref_left <= RLAT; ref_set_q <= refill_set; ref_tag_q <= refill_tag;
        end else if (ref_left > 0) begin
            ref_left <= ref_left - 1;
            if (ref_left == 1) begin
                ref_done <= 1'b1; st_v[ref_set_q] <= 1; st_t[ref_set_q] <= ref_tag_q;
            end
        end
        if (inval_valid) begin
            if (inval_all_ways) st_v[inval_set] <= 0;
            else if (st_v[inval_set] && st_t[inval_set] == inval_tag) st_v[inval_set] <= 0;
        end
    end

    cmo_ctrl #(.NUM_SETS(NS), .TAG_W(TW), .SID_W(SIDW), .TID_W(TIDW), .OP_W(OPW),
               .WCNT_W(WCW), .MCNT_W(MCW), .OP_CMO(OPC), .CMO_EN(1'b1)) i_cmo_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_size(req_size), .req_sid(req_sid), .req_tid(req_tid),
        .req_need_rsp(req_need_rsp), .req_phys(req_phys), .req_set(req_set),
        .req_tag(req_tag), .late_tag(late_tag), .wbuf_close(wbuf_close),
        .wbuf_pending(wbuf_pending), .look_set(look_set), .look_tag(look_tag),
        .look_miss_pend(look_miss_pend), .miss_count(miss_count), .look_hit(look_hit),
        .inval_valid(inval_valid), .inval_all_ways(inval_all_ways), .inval_set(inval_set),
        .inval_tag(inval_tag), .refill_valid(refill_valid), .refill_ready(refill_ready),
        .refill_set(refill_set), .refill_tag(refill_tag), .refill_done(refill_done),
        .rsp_valid(rsp_valid), .rsp_sid(rsp_sid), .rsp_tid(rsp_tid));

    cmo_ctrl #(.NUM_SETS(NS), .TAG_W(TW), .SID_W(SIDW), .TID_W(TIDW), .OP_W(OPW),
               .WCNT_W(WCW), .MCNT_W(MCW), .OP_CMO(OPC), .CMO_EN(1'b0)) i_cmo_ctrl_off (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(off_ready),
        .req_op(req_op), .req_size(req_size), .req_sid(req_sid), .req_tid(req_tid),
        .req_need_rsp(req_need_rsp), .req_phys(req_phys), .req_set(req_set),
        .req_tag(req_tag), .late_tag(late_tag), .wbuf_close(off_close),
        .wbuf_pending(wbuf_pending), .look_set(off_lset), .look_tag(off_ltag),
        .look_miss_pend(1'b0), .miss_count(miss_count), .look_hit(1'b0),
        .inval_valid(off_inv), .inval_all_ways(off_inv_all), .inval_set(off_iset),
        .inval_tag(off_itag), .refill_valid(off_ref), .refill_ready(1'b1),
        .refill_set(off_rset), .refill_tag(off_rtag), .refill_done(1'b0),
        .rsp_valid(off_rsp), .rsp_sid(off_sid), .rsp_tid(off_tid));

    // monitor
    int total = 0, fails = 0, cyc = 0;
    bit mon = 0, after_acc = 0;
    int busy, lpul, swn, swexp, swerr, cln, rfn, rspn, drerr, off_err = 0;
    logic [SIDW-1:0] got_sid;
    logic [TIDW-1:0] got_tid;

    always @(negedge clk) begin
        cyc++;
        if (off_ready || off_close || off_inv || off_ref || off_rsp) off_err++;
        if (mon) begin
            if (!req_ready) busy++;
            if (inval_valid && !inval_all_ways) lpul++;
            if (inval_valid && inval_all_ways) begin
                if (int'(inval_set) != swexp) swerr++;
                swexp++; swn++;
            end
            if (wbuf_close) cln++;
            if (refill_valid && refill_ready) rfn++;
            if (rsp_valid) begin rspn++; got_sid = rsp_sid; got_tid = rsp_tid; end
            if (after_acc && req_ready && wb_cnt > 0) drerr++;
        end
    end

    task automatic chk(bit ok, string req, int act, int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [2:0] code_of(int kind);
        case (kind)
            0: return 3'b000;
            1: return 3'b010;
            2: return 3'b100;
            3: return 3'b101;
            default: return 3'b111;
        endcase
    endfunction

    function automatic int maxi(int a, int b);
        return (a > b) ? a : b;
    endfunction

    // kind: 0 fence, 1 line inval, 2 inval all, 3 prefetch, 4 undefined subtype
    // pre: 0 set empty, 1 line present, 2 other tag present
    function automatic int exp_busy(int kind, bit phys, int pre, int m, int p);
        int base = phys ? 1 : 2;
        case (kind)
            0: return maxi(2, p) + 1;
            1: return maxi(base, m) + 1;
            2: return maxi(1, m) + NS + 1;
            3: begin
                if (m > 0) return maxi(base, m) + 1;
                if (pre == 1) return base + 1;
                return base + 3 + RLAT;
            end
            default: return 1;
        endcase
    endfunction

    task automatic run_op(int kind, bit phys, bit need, logic [SIDW-1:0] sid,
                          logic [TIDW-1:0] tid, logic [SW-1:0] set, logic [TW-1:0] tag,
                          int pre, int m, int p);
        bit ev [NS];
        logic [TW-1:0] et [NS];
        int n;
        int exp_l;
        int exp_rf;
        bit mism;
        @(posedge clk); #1;
        if (kind == 2) begin
            for (int i = 0; i < NS; i++) begin
                st_v[i] = ($urandom_range(0, 1) == 1);
                st_t[i] = TW'($urandom);
            end
        end
        if (m > 0) begin
            st_v[set] = 0; miss_left = m; miss_set = set; miss_tag = tag;
        end else begin
            st_v[set] = (pre != 0);
            st_t[set] = (pre == 2) ? (tag ^ 12'h5a5) : tag;
        end
        wb_cnt = p;
        for (int i = 0; i < NS; i++) begin ev[i] = st_v[i]; et[i] = st_t[i]; end
        if (m > 0) begin ev[set] = 1; et[set] = tag; end
        exp_l  = (kind == 1 && (m > 0 || pre == 1)) ? 1 : 0;
        exp_rf = (kind == 3 && m == 0 && pre != 1) ? 1 : 0;
        case (kind)
            1: if (ev[set] && et[set] == tag) ev[set] = 0;
            2: for (int i = 0; i < NS; i++) ev[i] = 0;
            3: begin ev[set] = 1; et[set] = tag; end
            default: ;
        endcase
        req_valid = 1; req_op = OPC; req_size = code_of(kind);
        req_sid = sid; req_tid = tid; req_need_rsp = need; req_phys = phys;
        req_set = set; req_tag = phys ? tag : ~tag; late_tag = phys ? ~tag : (tag ^ 12'h0f0);
        busy = 0; lpul = 0; swn = 0; swexp = 0; swerr = 0; cln = 0; rfn = 0; rspn = 0; drerr = 0;
        after_acc = 0; mon = 1;
        @(posedge clk); #1;
        req_valid = 0; after_acc = 1;
        late_tag = phys ? ~tag : tag;
        req_tag = TW'($urandom);
        n = 0;
        do begin @(negedge clk); n++; end while (!req_ready && n < 600);
        #1 mon = 0; after_acc = 0;
        chk(n < 600, "R12 completion", n, 600);
        chk(busy == exp_busy(kind, phys, pre, m, p),
            (kind == 0) ? "R4 busy" : (kind == 1) ? "R5 R6 R10 busy" :
            (kind == 2) ? "R8 busy" : (kind == 3) ? "R9 busy" : "R1 busy",
            busy, exp_busy(kind, phys, pre, m, p));
        chk(cln == ((kind == 0) ? 1 : 0), "R4 close", cln, (kind == 0) ? 1 : 0);
        chk(drerr == 0, "R4 drain hold", drerr, 0);
        chk(lpul == exp_l, "R5 R7 line strobes", lpul, exp_l);
        chk(swn == ((kind == 2) ? NS : 0), "R8 sweep count", swn, (kind == 2) ? NS : 0);
        chk(swerr == 0, "R8 sweep order", swerr, 0);
        chk(rfn == exp_rf, "R9 refill count", rfn, exp_rf);
        chk(rspn == (need ? 1 : 0), "R11 response count", rspn, need ? 1 : 0);
        if (need) chk(got_sid == sid && got_tid == tid, "R11 response ids",
                      int'({got_sid, got_tid}), int'({sid, tid}));
        mism = 0;
        for (int i = 0; i < NS; i++)
            if (st_v[i] != ev[i] || (ev[i] && st_t[i] != et[i])) mism = 1;
        chk(!mism, "R10 R7 array state", mism, 0);
    endtask

    initial begin : watchdog
        wait (cyc > 150000);
        fails++; total++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < NS; i++) begin st_v[i] = 0; st_t[i] = '0; end
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        chk(req_ready === 1'b1, "R12 reset ready", req_ready, 1);
        chk({rsp_valid, inval_valid, refill_valid, wbuf_close} === 4'b0, "R11 reset idle outputs",
            int'({rsp_valid, inval_valid, refill_valid, wbuf_close}), 0);

        // R3: wrong opcode ignored
        @(posedge clk); #1;
        req_valid = 1; req_op = OPC + 1'b1; req_size = 3'b000; wb_cnt = 0;
        busy = 0; cln = 0; rspn = 0; mon = 1;
        @(posedge clk); #1 req_valid = 0;
        repeat (3) @(negedge clk);
        #1 mon = 0;
        chk(busy == 0 && cln == 0 && rspn == 0, "R3 other opcode ignored", busy + cln + rspn, 0);
        chk(req_ready == 1'b1, "R3 ready kept", req_ready, 1);

        // directed corners
        run_op(0, 1, 1, 3'd1, 6'd10, 4'd0, 12'h000, 0, 0, 5);
        run_op(0, 1, 0, 3'd2, 6'd11, 4'd0, 12'h000, 0, 0, 0);
        run_op(1, 1, 1, 3'd3, 6'd12, 4'd5, 12'h123, 1, 0, 0);
        run_op(1, 0, 1, 3'd4, 6'd13, 4'd6, 12'h456, 1, 0, 0);
        run_op(1, 1, 1, 3'd5, 6'd14, 4'd7, 12'h789, 0, 4, 0);
        run_op(1, 0, 0, 3'd5, 6'd15, 4'd7, 12'h78a, 0, 1, 0);
        run_op(1, 1, 1, 3'd6, 6'd16, 4'd8, 12'habc, 2, 0, 0);
        run_op(1, 0, 1, 3'd6, 6'd17, 4'd9, 12'hab0, 0, 0, 0);
        run_op(2, 1, 1, 3'd7, 6'd18, 4'd1, 12'h111, 0, 0, 0);
        run_op(2, 1, 1, 3'd0, 6'd19, 4'd2, 12'h222, 0, 3, 0);
        run_op(3, 1, 1, 3'd1, 6'd20, 4'd3, 12'h333, 1, 0, 0);
        run_op(3, 1, 1, 3'd2, 6'd21, 4'd4, 12'h444, 0, 0, 0);
        run_op(3, 0, 1, 3'd3, 6'd22, 4'd10, 12'h555, 2, 0, 0);
        run_op(3, 1, 0, 3'd4, 6'd23, 4'd11, 12'h666, 0, 3, 0);
        run_op(4, 1, 1, 3'd5, 6'd24, 4'd12, 12'h777, 0, 0, 0);

        // constrained random mix
        for (int k = 0; k < 40; k++) begin
            int kind = $urandom_range(0, 4);
            int m = 0;
            int p = 0;
            if (kind >= 1 && kind <= 3 && ($urandom_range(0, 2) == 0)) m = $urandom_range(1, 5);
            if (kind == 0) p = $urandom_range(0, 7);
            run_op(kind, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                   SIDW'($urandom), TIDW'($urandom), SW'($urandom), TW'($urandom),
                   $urandom_range(0, 2), m, p);
        end

        chk(off_err == 0, "R2 disabled instance silent", off_err, 0);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule